// File: doc/BRIEF.md
# Logical-to-Physical Column Decoder

This block sits between a wide parallel image-data bus and the per-channel drive logic of a line modulator. Each bus word packs eight channels, and every channel arrives as a pair of short logical codes: one for amplitude and one for edge delay. As each word arrives, the block looks up both codes in small programmable tables. It stores the full-resolution amplitude and delay of every channel in a column store.

The column store has two banks. Incoming words fill one bank while the drive side reads the bank filled during the previous column, one channel per cycle by channel address. A column strobe swaps the two roles. A short column, or a code with no table entry, raises a sticky error flag.

The tables are loaded through a configuration write port while the run-enable input is low. A coded read command returns a table entry or the error status on a separate reply output one cycle later.

Top module: `colDecoder`

## Requirements
- R1: Lane k of a bus word sits in bits [6k+5:6k]. Its upper three bits are the amplitude code and its lower three bits are the delay code. Word number w of a column (counted from 0 since the last strobe) fills channels w*8 to w*8+7, with lane k going to channel w*8+k.
- R2: Every accepted word is converted in the cycle it is accepted. The amplitude code selects one of seven 10-bit amplitude entries (codes 0 to 6). The delay code selects one of eight 8-bit delay entries.
- R3: Amplitude code 7 stores amplitude 0 and sets `errBadCode`, which stays set until reset.
- R4: Words are written into the fill bank while readout comes from the other bank. The roles swap on each `colStrobe`. `outAmp`/`outDly` show the read-bank entry for `rdChan` one cycle after `rdChan` is applied. A word presented together with a strobe belongs to the column being closed.
- R5: Words beyond COL_WORDS (4) in one column are ignored. If a strobe closes a column with fewer than COL_WORDS accepted words, `errUnderrun` is set and stays set until reset. The banks still swap, and channels that were not written keep that bank's older contents.
- R6: When `cfgWe` is high, `cfgSel`=0 writes amplitude entry `cfgAddr` and `cfgSel`=1 writes delay entry `cfgAddr`, taking the delay from `cfgData[7:0]`. A write to amplitude address 7 is ignored. Every configuration write is ignored while `runEn` is high.
- R7: A read command (`rdValid`) gives `upValid`=1 in the next cycle, and `upData` then holds the selected item:
  - `rdTarget`=0 returns amplitude entry `rdAddr`, with address 7 reading as 0.
  - `rdTarget`=1 returns delay entry `rdAddr`.
  - `rdTarget`=2 returns status: bit 0 is `errBadCode` and bit 1 is `errUnderrun`.
  - `rdTarget`=3 returns 0.

  Without a command, `upValid` is 0 in the next cycle.
- R8: After reset, all table entries, bank entries, outputs and flags are 0, and bank 0 is the fill bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run mode; blocks table writes |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 1 | 0 amplitude table, 1 delay table |
| cfgAddr | input | 3 | Table entry address |
| cfgData | input | 10 | Table write data |
| inValid | input | 1 | Bus word valid |
| inWord | input | 48 | Eight packed 6-bit channel codes |
| colStrobe | input | 1 | Column boundary; swaps banks |
| rdChan | input | 5 | Readout channel address |
| outAmp | output | 10 | Amplitude of the addressed channel |
| outDly | output | 8 | Delay of the addressed channel |
| rdValid | input | 1 | Read command |
| rdTarget | input | 2 | Read target select |
| rdAddr | input | 3 | Table address for a read |
| upValid | output | 1 | Reply valid |
| upData | output | 10 | Reply data |
| errBadCode | output | 1 | Sticky unmapped-amplitude-code flag |
| errUnderrun | output | 1 | Sticky short-column flag |

## Verification
A wrong word pointer or bank select does not show while a column is being filled. It shows one strobe later, when the readout port returns a misplaced channel or the previous column's values at its one-cycle latency. A lost or blocked table write shows only when a later word uses that code, or at once through a read command one cycle after it is issued. A flag that fails to set or to hold shows in the cycle after the offending word or strobe, both on the flag pin and in the status read.

// File: rtl/colDecPkg.sv
package colDecPkg;

  // Per-cycle strobes issued by the control to the datapath.
  typedef struct packed {
    logic ampWe;   // write amplitude table entry
    logic dlyWe;   // write delay table entry
    logic wordWe;  // store the converted bus word in the fill bank
    logic wrBank;  // index of the current fill bank
    logic rdReq;   // capture a reply for the read command
  } ctlStrobes_t;

endpackage

// File: rtl/colDecDatapath.sv
module colDecDatapath
  import colDecPkg::*;
#(
  parameter int LANES     = 8,
  parameter int CODE_W    = 3,
  parameter int AMP_W     = 10,
  parameter int DLY_W     = 8,
  parameter int COL_WORDS = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctlStrobes_t                           ctl,
  input  logic [$clog2(COL_WORDS+1)-1:0]        wordIdx,
  input  logic [LANES*2*CODE_W-1:0]             inWord,
  input  logic [CODE_W-1:0]                     cfgAddr,
  input  logic [AMP_W-1:0]                      cfgData,
  input  logic [$clog2(COL_WORDS*LANES)-1:0]    rdChan,
  input  logic [1:0]                            rdTarget,
  input  logic [CODE_W-1:0]                     rdAddr,
  input  logic [1:0]                            flags,
  output logic                                  badSeen,
  output logic [AMP_W-1:0]                      outAmp,
  output logic [DLY_W-1:0]                      outDly,
  output logic [AMP_W-1:0]                      upData
);
  localparam int LANE_W = 2 * CODE_W;
  localparam int N_CODE = 1 << CODE_W;
  localparam int N_CH   = COL_WORDS * LANES;
  localparam int CH_W   = $clog2(N_CH);
  localparam logic [CODE_W-1:0] BAD_CODE = '1;

  logic [AMP_W-1:0] ampTab  [N_CODE];
  logic [DLY_W-1:0] dlyTab  [N_CODE];
  logic [AMP_W-1:0] ampBank [2][N_CH];
  logic [DLY_W-1:0] dlyBank [2][N_CH];
  logic [AMP_W-1:0] laneAmp [LANES];
  logic [DLY_W-1:0] laneDly [LANES];
  logic [LANES-1:0] laneBad;

  // Real-time conversion of every lane of the incoming word.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CODE_W-1:0] aCode;
    logic [CODE_W-1:0] dCode;
    assign aCode = inWord[l*LANE_W+CODE_W +: CODE_W];
    assign dCode = inWord[l*LANE_W +: CODE_W];
    assign laneBad[l] = (aCode == BAD_CODE);
    assign laneAmp[l] = laneBad[l] ? '0 : ampTab[aCode];
    assign laneDly[l] = dlyTab[dCode];
  end

  assign badSeen = |laneBad;

  // Logical-to-physical tables.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_CODE; i++) begin
        ampTab[i] <= '0;
        dlyTab[i] <= '0;
      end
    end else begin
      if (ctl.ampWe && cfgAddr != BAD_CODE) ampTab[cfgAddr] <= cfgData;
      if (ctl.dlyWe) dlyTab[cfgAddr] <= cfgData[DLY_W-1:0];
    end
  end

  // Ping-pong column banks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c < N_CH; c++) begin
          ampBank[b][c] <= '0;
          dlyBank[b][c] <= '0;
        end
      end
    end else if (ctl.wordWe) begin
      for (int l = 0; l < LANES; l++) begin
        ampBank[ctl.wrBank][CH_W'(wordIdx) * CH_W'(LANES) + CH_W'(l)] <= laneAmp[l];
        dlyBank[ctl.wrBank][CH_W'(wordIdx) * CH_W'(LANES) + CH_W'(l)] <= laneDly[l];
      end
    end
  end

  // Readout of the bank that is not being filled.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAmp <= '0;
      outDly <= '0;
    end else begin
      outAmp <= ampBank[~ctl.wrBank][rdChan];
      outDly <= dlyBank[~ctl.wrBank][rdChan];
    end
  end

  // Reply to read commands.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      upData <= '0;
    end else if (ctl.rdReq) begin
      case (rdTarget)
        2'd0:    upData <= (rdAddr == BAD_CODE) ? '0 : ampTab[rdAddr];
        2'd1:    upData <= AMP_W'(dlyTab[rdAddr]);
        2'd2:    upData <= AMP_W'(flags);
        default: upData <= '0;
      endcase
    end else begin
      upData <= '0;
    end
  end

endmodule

// File: rtl/colDecControl.sv
module colDecControl
  import colDecPkg::*;
#(
  parameter int COL_WORDS = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             runEn,
  input  logic                             cfgWe,
  input  logic                             cfgSel,
  input  logic                             inValid,
  input  logic                             colStrobe,
  input  logic                             rdValid,
  input  logic                             badSeen,
  output ctlStrobes_t                      ctl,
  output logic [$clog2(COL_WORDS+1)-1:0]   wordIdx,
  output logic                             errBadCode,
  output logic                             errUnderrun,
  output logic                             upValid
);
  localparam int PTR_W = $clog2(COL_WORDS + 1);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(COL_WORDS);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] closingCount;
  logic             wrBank;

  always_comb begin
    ctl.ampWe  = cfgWe && !runEn && !cfgSel;
    ctl.dlyWe  = cfgWe && !runEn && cfgSel;
    ctl.wordWe = inValid && (wrPtr < FULL);
    ctl.wrBank = wrBank;
    ctl.rdReq  = rdValid;
    wordIdx    = wrPtr;
    closingCount = wrPtr + PTR_W'(ctl.wordWe);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      wrBank      <= 1'b0;
      errBadCode  <= 1'b0;
      errUnderrun <= 1'b0;
      upValid     <= 1'b0;
    end else begin
      upValid <= rdValid;
      if (ctl.wordWe && badSeen) errBadCode <= 1'b1;
      if (colStrobe) begin
        wrBank <= ~wrBank;
        wrPtr  <= '0;
        if (closingCount != FULL) errUnderrun <= 1'b1;
      end else if (ctl.wordWe) begin
        wrPtr <= wrPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/colDecoder.sv
module colDecoder
  import colDecPkg::*;
#(
  parameter int LANES     = 8,
  parameter int CODE_W    = 3,
  parameter int AMP_W     = 10,
  parameter int DLY_W     = 8,
  parameter int COL_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                runEn,
  input  logic                                cfgWe,
  input  logic                                cfgSel,
  input  logic [CODE_W-1:0]                   cfgAddr,
  input  logic [AMP_W-1:0]                    cfgData,
  input  logic                                inValid,
  input  logic [LANES*2*CODE_W-1:0]           inWord,
  input  logic                                colStrobe,
  input  logic [$clog2(COL_WORDS*LANES)-1:0]  rdChan,
  output logic [AMP_W-1:0]                    outAmp,
  output logic [DLY_W-1:0]                    outDly,
  input  logic                                rdValid,
  input  logic [1:0]                          rdTarget,
  input  logic [CODE_W-1:0]                   rdAddr,
  output logic                                upValid,
  output logic [AMP_W-1:0]                    upData,
  output logic                                errBadCode,
  output logic                                errUnderrun
);
  localparam int PTR_W = $clog2(COL_WORDS + 1);

  ctlStrobes_t      ctl;
  logic [PTR_W-1:0] wordIdx;
  logic             badSeen;

  colDecControl #(.COL_WORDS(COL_WORDS)) i_ctl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .inValid(inValid), .colStrobe(colStrobe), .rdValid(rdValid),
    .badSeen(badSeen), .ctl(ctl), .wordIdx(wordIdx),
    .errBadCode(errBadCode), .errUnderrun(errUnderrun), .upValid(upValid)
  );

  colDecDatapath #(
    .LANES(LANES), .CODE_W(CODE_W), .AMP_W(AMP_W), .DLY_W(DLY_W),
    .COL_WORDS(COL_WORDS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIdx(wordIdx), .inWord(inWord),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .rdChan(rdChan),
    .rdTarget(rdTarget), .rdAddr(rdAddr),
    .flags({errUnderrun, errBadCode}), .badSeen(badSeen),
    .outAmp(outAmp), .outDly(outDly), .upData(upData)
  );

endmodule

// File: rtl/colDecChecker.sv
module colDecChecker #(
  parameter int LANES     = 8,
  parameter int CODE_W    = 3,
  parameter int AMP_W     = 10,
  parameter int DLY_W     = 8,
  parameter int COL_WORDS = 4
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                inValid,
  input logic [LANES*2*CODE_W-1:0]           inWord,
  input logic                                colStrobe,
  input logic [$clog2(COL_WORDS*LANES)-1:0]  rdChan,
  input logic [AMP_W-1:0]                    outAmp,
  input logic [DLY_W-1:0]                    outDly,
  input logic                                rdValid,
  input logic                                upValid,
  input logic                                errBadCode,
  input logic                                errUnderrun
);
  localparam int PW = $clog2(COL_WORDS + 1);

  logic [PW-1:0] cnt;
  logic          accept;
  logic [PW-1:0] closing;
  logic          anyBad;

  always_comb begin
    anyBad = 1'b0;
    for (int l = 0; l < LANES; l++)
      anyBad = anyBad | (&inWord[l*2*CODE_W+CODE_W +: CODE_W]);
    accept  = inValid && (cnt < PW'(COL_WORDS));
    closing = cnt + PW'(accept);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (colStrobe) cnt <= '0;
    else if (accept) cnt <= cnt + 1'b1;
  end

  AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    accept && anyBad |=> errBadCode);  // R3
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errBadCode |=> errBadCode);  // R3
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe && closing != PW'(COL_WORDS) |=> errUnderrun);  // R5
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errUnderrun |=> errUnderrun);  // R5
  AST_REPLY_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> upValid);  // R7
  AST_REPLY_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !upValid);  // R7
  AST_READ_BANK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !colStrobe && !$past(colStrobe) && $stable(rdChan)
    |=> $stable(outAmp) && $stable(outDly));  // R4

endmodule

bind colDecoder colDecChecker #(
  .LANES(LANES), .CODE_W(CODE_W), .AMP_W(AMP_W), .DLY_W(DLY_W),
  .COL_WORDS(COL_WORDS)
) i_chk (.*);

// File: tb/test_colDecoder.sv
`timescale 1ns/1ps
module test_colDecoder;
  localparam int LANES = 8, CODE_W = 3, AMP_W = 10, DLY_W = 8, COL_WORDS = 4;
  localparam int N_CH = COL_WORDS * LANES;
  localparam int CH_W = $clog2(N_CH);

  logic clk = 0, rstN = 0, runEn = 0, cfgWe = 0, cfgSel = 0;
  logic [CODE_W-1:0] cfgAddr = '0, rdAddr = '0;
  logic [AMP_W-1:0] cfgData = '0;
  logic inValid = 0, colStrobe = 0, rdValid = 0;
  logic [LANES*2*CODE_W-1:0] inWord = '0;
  logic [CH_W-1:0] rdChan = '0;
  logic [1:0] rdTarget = '0;
  logic [AMP_W-1:0] outAmp, upData;
  logic [DLY_W-1:0] outDly;
  logic upValid, errBadCode, errUnderrun;

  colDecoder i_colDecoder (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  // Bench model
  int ampT[8], dlyT[8];
  int mAmp[2][N_CH], mDly[2][N_CH];
  int mBank = 0, mCnt = 0, mBad = 0, mUnd = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [47:0] genWord(bit allowBad);
    logic [47:0] w;
    for (int k = 0; k < LANES; k++) begin
      w[k*6+3 +: 3] = allowBad ? 3'($urandom % 8) : 3'($urandom % 7);
      w[k*6 +: 3]   = 3'($urandom % 8);
    end
    return w;
  endfunction

  function automatic int expReply(int tgt, int addr);
    case (tgt)
      0: return (addr == 7) ? 0 : ampT[addr];
      1: return dlyT[addr];
      2: return mUnd * 2 + mBad;
      default: return 0;
    endcase
  endfunction

  task automatic cfgWrite(bit sel, int addr, int data);
    cfgWe = 1; cfgSel = sel; cfgAddr = 3'(addr); cfgData = 10'(data);
    if (!runEn) begin
      if (sel) dlyT[addr] = data & 8'hFF;
      else if (addr != 7) ampT[addr] = data;
    end
    @(negedge clk); cfgWe = 0;
  endtask

  task automatic readCmd(string req, int tgt, int addr);
    rdValid = 1; rdTarget = 2'(tgt); rdAddr = 3'(addr);
    @(negedge clk); rdValid = 0;
    check(req, int'(upValid), 1);
    check(req, int'(upData), expReply(tgt, addr));
  endtask

  task automatic sendWord(logic [47:0] w);
    inValid = 1; inWord = w;
    if (mCnt < COL_WORDS) begin
      for (int k = 0; k < LANES; k++) begin
        int a = int'(w[k*6+3 +: 3]);
        int d = int'(w[k*6 +: 3]);
        mAmp[mBank][mCnt*LANES+k] = (a == 7) ? 0 : ampT[a];
        mDly[mBank][mCnt*LANES+k] = dlyT[d];
        if (a == 7) mBad = 1;
      end
      mCnt++;
    end
    @(negedge clk); inValid = 0;
  endtask

  task automatic strobe();
    colStrobe = 1;
    if (mCnt != COL_WORDS) mUnd = 1;
    mBank ^= 1; mCnt = 0;
    @(negedge clk); colStrobe = 0;
  endtask

  task automatic checkChan(string req, int ch);
    rdChan = CH_W'(ch);
    @(negedge clk);
    check(req, int'(outAmp), mAmp[mBank^1][ch]);
    check(req, int'(outDly), mDly[mBank^1][ch]);
  endtask

  task automatic checkAll(string req);
    for (int c = 0; c < N_CH; c++) checkChan(req, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    foreach (ampT[i]) ampT[i] = 0;
    foreach (dlyT[i]) dlyT[i] = 0;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < N_CH; c++) begin mAmp[b][c] = 0; mDly[b][c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8: reset state
    check("R8 outAmp", int'(outAmp), 0);
    check("R8 outDly", int'(outDly), 0);
    check("R8 upValid", int'(upValid), 0);
    check("R8 errBadCode", int'(errBadCode), 0);
    check("R8 errUnderrun", int'(errUnderrun), 0);
    readCmd("R8 amp table cleared", 0, 3);
    readCmd("R8 delay table cleared", 1, 5);
    @(negedge clk);
    check("R7 upValid idle", int'(upValid), 0);

    // R6: load tables, including a blocked write to amplitude address 7
    for (int i = 0; i < 8; i++) cfgWrite(0, i, 100 + 37 * i + ($urandom % 20));
    for (int i = 0; i < 8; i++) cfgWrite(1, i, 3 + 29 * i + ($urandom % 9));
    for (int i = 0; i < 8; i++) readCmd("R6 amp readback", 0, i);
    for (int i = 0; i < 8; i++) readCmd("R6 delay readback", 1, i);
    readCmd("R7 unused target", 3, 2);

    // R6: writes ignored in run mode
    runEn = 1;
    cfgWrite(0, 2, 1023);
    cfgWrite(1, 4, 255);
    readCmd("R6 amp write blocked by runEn", 0, 2);
    readCmd("R6 delay write blocked by runEn", 1, 4);

    // R1 R2 R4: random full columns, readout checked while the next fills
    for (int col = 0; col < 4; col++) begin
      for (int w = 0; w < COL_WORDS; w++) begin
        sendWord(genWord(0));
        checkChan("R4 read bank held during fill", $urandom % N_CH);
      end
      strobe();
      checkAll("R1 R2 column contents");
    end
    check("R3 no bad code yet", int'(errBadCode), 0);
    check("R5 no underrun yet", int'(errUnderrun), 0);

    // R1 directed: distinct codes per lane to expose lane ordering
    for (int w = 0; w < COL_WORDS; w++) begin
      logic [47:0] dw;
      for (int k = 0; k < LANES; k++) begin
        dw[k*6+3 +: 3] = 3'((k + w) % 7);
        dw[k*6 +: 3]   = 3'(7 - k);
      end
      sendWord(dw);
    end
    strobe();
    checkAll("R1 lane ordering");

    // R5: extra word beyond COL_WORDS ignored
    for (int w = 0; w < COL_WORDS + 1; w++) sendWord(genWord(0));
    strobe();
    checkAll("R5 extra word ignored");
    check("R5 full column no underrun", int'(errUnderrun), 0);

    // R3: unmapped amplitude code
    sendWord(48'hFFFF_FFFF_FFFF);
    check("R3 flag set", int'(errBadCode), 1);
    for (int w = 1; w < COL_WORDS; w++) sendWord(genWord(1));
    strobe();
    checkAll("R3 code 7 stores zero");
    readCmd("R3 status bit0", 2, 0);

    // R5: short column still swaps, underrun flagged
    sendWord(genWord(0));
    sendWord(genWord(0));
    strobe();
    check("R5 underrun set", int'(errUnderrun), 1);
    checkAll("R5 short column swap");
    readCmd("R7 status after errors", 2, 0);

    // R4: word presented together with the strobe closes the column
    for (int w = 0; w < COL_WORDS - 1; w++) sendWord(genWord(0));
    begin
      logic [47:0] lw = genWord(0);
      inValid = 1; inWord = lw; colStrobe = 1;
      for (int k = 0; k < LANES; k++) begin
        mAmp[mBank][mCnt*LANES+k] = ampT[int'(lw[k*6+3 +: 3])];
        mDly[mBank][mCnt*LANES+k] = dlyT[int'(lw[k*6 +: 3])];
      end
      mBank ^= 1; mCnt = 0;
      @(negedge clk); inValid = 0; colStrobe = 0;
    end
    checkAll("R4 word with strobe");
    check("R3 flag sticky", int'(errBadCode), 1);
    check("R5 flag sticky", int'(errUnderrun), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule